// File: doc/BRIEF.md
# Serial EEPROM Slave Front End

This block is the slave-side front end of a small serial EEPROM on a four-wire SPI bus (mode 0). The array size is a parameter and may be 128, 256 or 512 bytes. The SPI pins are oversampled on a system clock. An active-low select opens each transaction, and the first byte is the instruction.

A read instruction carries the ninth address bit inside the opcode and is followed by one address byte. Data then streams out MSB-first from an internal byte array, and the address advances and wraps around for as long as the master keeps clocking. A status-write instruction updates two block-protect bits. It takes effect only when select is released after exactly sixteen clocks, and it then starts a modelled internal write cycle. While that cycle runs, read instructions are refused. A status-read instruction reports the protect bits and the busy flag. A separate combinational port reports whether a given address lies in the protected part of the array.

The serial output comes out as a data bit plus an output-enable, so the pad logic can drive the line or release it.

Top module: `eep_spi_front`

## Requirements
- R1: After reset the protect bits are 00, the busy flag is clear, and `miso_oe` is 0.
- R2: A read opcode has the form 0000_A8_011 and is followed by the address byte A7..A0, MSB first. Every input bit is taken on a rising `sck` edge. `miso_oe` stays 0 during the opcode and address bits. Data bits then leave MSB-first, one bit per falling `sck` edge, starting at the fall that follows the last address bit. The byte at address a holds (a*PAT_MUL + PAT_ADD) mod 256.
- R3: After each byte is sent, the read address advances by one. Above MEM_BYTES-1 it wraps to 0, so a read may run on for any number of bytes.
- R4: Raising `cs_n` ends a read at any bit, including in the middle of a byte, and `miso_oe` returns to 0.
- R5: A read opcode that arrives while busy is rejected. `miso_oe` stays 0 until `cs_n` rises.
- R6: The status-write opcode is 0x01 and is followed by one data byte. Data bits 3 and 2 become BP1 and BP0. The write commits only if `cs_n` rises after exactly 16 rising `sck` edges. With 15 or 17 edges the protect bits do not change.
- R7: A committed status write sets busy for BUSY_CYCLES system clocks. A status write issued while busy is ignored.
- R8: The status-read opcode is 0x05. It returns the byte {0000, BP1, BP0, 0, busy} and repeats it while clocks continue.
- R9: `chk_prot` is 1 for addresses in the protected region. The region is none for BP=00, the top quarter of the array for BP=01, the top half for BP=10, and every address for BP=11.
- R10: Any other opcode is ignored until `cs_n` rises. `miso_oe` stays 0 and the status does not change.
- R11: Address bits above the array size are ignored. A8 is ignored at 256 bytes, and A8 and A7 are ignored at 128 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Drive enable for `miso`; 0 means high impedance |
| chk_addr | input | ADDR_W | Address presented to the protection check |
| chk_prot | output | 1 | 1 when `chk_addr` lies in the protected region |

## Verification
Three instances (512, 256 and 128 bytes) share one bus, so a single stream of transactions shows how each size masks and wraps addresses.

Directed reads that start just below the top of each array separate a wrap error from an increment error. Random start addresses with random A8 values and lengths show whether the opcode-borne address bit is honoured or dropped.

Status writes cut short at 15 clocks or stretched to 17 clocks are set against a write of exactly 16 clocks, which isolates the commit condition. Reads and a second status write issued during the busy window show that requests are refused while busy. Protection is probed at each quarter and half boundary for all four BP codes.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DOUT,
    ST_SOUT,
    ST_WST,
    ST_DROP
  } fe_state_t;

  localparam logic [7:0] OP_WR_STATUS = 8'h01;
  localparam logic [7:0] OP_RD_STATUS = 8'h05;

  // read opcode: upper nibble zero, low three bits 011, bit 3 is address bit 8
  function automatic logic is_read_op(input logic [7:0] b);
    return (b[7:4] == 4'h0) && (b[2:0] == 3'b011);
  endfunction

endpackage

// File: rtl/eep_spi_sync.sv
module eep_spi_sync (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic cs_act,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] IDLE_LVL = 3'b100; // {cs_n, sck, mosi}

  logic [NPIN-1:0] pin_in;
  logic [NPIN-1:0] st1, st2, st3;

  assign pin_in = {cs_n, sck, mosi};

  genvar g;
  generate
    for (g = 0; g < NPIN; g++) begin : g_pin
      always_ff @(posedge clk) begin
        if (rst) begin
          st1[g] <= IDLE_LVL[g];
          st2[g] <= IDLE_LVL[g];
          st3[g] <= IDLE_LVL[g];
        end else begin
          st1[g] <= pin_in[g];
          st2[g] <= st1[g];
          st3[g] <= st2[g];
        end
      end
    end
  endgenerate

  assign cs_act   = ~st2[2];
  assign cs_fall  = ~st2[2] &  st3[2];
  assign cs_rise  =  st2[2] & ~st3[2];
  assign sck_rise =  st2[1] & ~st3[1];
  assign sck_fall = ~st2[1] &  st3[1];
  assign mosi_s   =  st2[0];

endmodule

// File: rtl/eep_rom.sv
module eep_rom #(
  parameter int DEPTH   = 512,
  parameter int PAT_MUL = 29,
  parameter int PAT_ADD = 90,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [7:0]    q
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 8'((i * PAT_MUL + PAT_ADD) % 256);
    end
  end

  always_ff @(posedge clk) begin
    q <= mem[addr];
  end

endmodule

// File: rtl/eep_prot_check.sv
module eep_prot_check #(
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        bp,
  output logic              hit
);
  always_comb begin
    unique case (bp)
      2'b00: hit = 1'b0;
      2'b01: hit = addr[ADDR_W-1] & addr[ADDR_W-2];
      2'b10: hit = addr[ADDR_W-1];
      default: hit = 1'b1;
    endcase
  end

endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
  parameter int CYCLES = 64,
  localparam int CW    = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (start) begin
      remain <= LOAD;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign busy = (remain != '0);

endmodule

// File: rtl/eep_spi_front.sv
module eep_spi_front
  import eep_pkg::*;
#(
  parameter int MEM_BYTES   = 512,
  parameter int BUSY_CYCLES = 64,
  parameter int PAT_MUL     = 29,
  parameter int PAT_ADD     = 90,
  localparam int ADDR_W     = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_prot
);
  localparam int CNT_W = 5;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_OP   = 5'd7;
  localparam logic [CNT_W-1:0] CNT_ARG  = 5'd15;
  localparam logic [CNT_W-1:0] CNT_WRSR = 5'd16;

  logic cs_act, cs_fall, cs_rise, sck_rise, sck_fall, mosi_s;

  eep_spi_sync u_sync (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sck      (sck),
    .mosi     (mosi),
    .cs_act   (cs_act),
    .cs_fall  (cs_fall),
    .cs_rise  (cs_rise),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_s   (mosi_s)
  );

  fe_state_t         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [7:0]        in_sr;
  logic              a8_q;
  logic [ADDR_W-1:0] rd_addr;
  logic [1:0]        bp_q;
  logic [1:0]        bp_pend;
  logic [7:0]        out_sr;
  logic [2:0]        out_cnt;
  logic              miso_q;
  logic              oe_q;

  logic [7:0] in_byte;
  logic [8:0] full_addr;
  logic [7:0] mem_q;
  logic [7:0] status_byte;
  logic [7:0] load_byte;
  logic       busy;
  logic       commit;
  logic       st_sout;
  logic       st_dout;

  assign in_byte     = {in_sr[6:0], mosi_s};
  assign full_addr   = {a8_q, in_byte};
  assign status_byte = {4'b0000, bp_q, 1'b0, busy};
  assign st_sout     = (state == ST_SOUT);
  assign st_dout     = (state == ST_DOUT);
  assign load_byte   = st_sout ? status_byte : mem_q;
  assign commit      = cs_rise && (state == ST_WST) && (bit_cnt == CNT_WRSR);

  eep_rom #(
    .DEPTH   (MEM_BYTES),
    .PAT_MUL (PAT_MUL),
    .PAT_ADD (PAT_ADD)
  ) u_rom (
    .clk  (clk),
    .addr (rd_addr),
    .q    (mem_q)
  );

  eep_busy_timer #(
    .CYCLES (BUSY_CYCLES)
  ) u_busy (
    .clk   (clk),
    .rst   (rst),
    .start (commit),
    .busy  (busy)
  );

  eep_prot_check #(
    .ADDR_W (ADDR_W)
  ) u_prot (
    .addr (chk_addr),
    .bp   (bp_q),
    .hit  (chk_prot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      in_sr   <= '0;
      a8_q    <= 1'b0;
      rd_addr <= '0;
      bp_q    <= 2'b00;
      bp_pend <= 2'b00;
      out_sr  <= '0;
      out_cnt <= '0;
      miso_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (cs_fall) begin
      state   <= ST_CMD;
      bit_cnt <= '0;
      out_cnt <= '0;
      oe_q    <= 1'b0;
    end else if (cs_rise) begin
      state  <= ST_IDLE;
      oe_q   <= 1'b0;
      miso_q <= 1'b0;
      if (commit) begin
        bp_q <= bp_pend;
      end
    end else if (cs_act) begin
      if (sck_rise && state != ST_IDLE) begin
        in_sr <= in_byte;
        if (bit_cnt != CNT_MAX) begin
          bit_cnt <= bit_cnt + 1'b1;
        end
        unique case (state)
          ST_CMD: begin
            if (bit_cnt == CNT_OP) begin
              if (is_read_op(in_byte)) begin
                a8_q  <= in_byte[3];
                state <= busy ? ST_DROP : ST_ADDR;
              end else if (in_byte == OP_RD_STATUS) begin
                state <= ST_SOUT;
              end else if (in_byte == OP_WR_STATUS && !busy) begin
                state <= ST_WST;
              end else begin
                state <= ST_DROP;
              end
            end
          end
          ST_ADDR: begin
            if (bit_cnt == CNT_ARG) begin
              rd_addr <= full_addr[ADDR_W-1:0];
              state   <= ST_DOUT;
            end
          end
          ST_WST: begin
            if (bit_cnt == CNT_ARG) begin
              bp_pend <= in_byte[3:2];
            end
          end
          default: ;
        endcase
      end
      if (sck_fall && (st_dout || st_sout)) begin
        oe_q    <= 1'b1;
        out_cnt <= out_cnt + 3'd1;
        if (out_cnt == 3'd0) begin
          miso_q <= load_byte[7];
          out_sr <= {load_byte[6:0], 1'b0};
          if (st_dout) begin
            rd_addr <= rd_addr + 1'b1;
          end
        end else begin
          miso_q <= out_sr[7];
          out_sr <= {out_sr[6:0], 1'b0};
        end
      end
    end
  end

  assign miso    = miso_q;
  assign miso_oe = oe_q;

endmodule

// File: rtl/eep_spi_front_chk.sv
module eep_spi_front_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_rise,
  input logic       sck_fall,
  input logic       miso_oe,
  input logic       busy,
  input logic [1:0] bp,
  input logic       st_sout
);

  // R4: releasing select always takes the output driver off the line
  a_r4_oe_off_after_deselect: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> !miso_oe);

  // R6: protect bits change only at a select release
  a_r6_bp_only_at_deselect: assert property (@(posedge clk) disable iff (rst)
    !cs_rise |=> $stable(bp));

  // R7: any change of protect bits coincides with a running write cycle
  a_r7_busy_after_bp_change: assert property (@(posedge clk) disable iff (rst)
    (bp != $past(bp)) |-> busy);

  // R5: while busy, only a status read may drive the line
  a_r5_only_status_while_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && miso_oe) |-> st_sout);

  // R2: the driver turns on only after a falling serial clock edge
  a_r2_oe_rises_on_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(miso_oe) |-> $past(sck_fall));

endmodule

bind eep_spi_front eep_spi_front_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_rise  (cs_rise),
  .sck_fall (sck_fall),
  .miso_oe  (miso_oe),
  .busy     (busy),
  .bp       (bp_q),
  .st_sout  (st_sout)
);

// File: tb/test_eep_spi_front.sv
module test_eep_spi_front;
  localparam int HALF = 8;
  localparam int BUSY = 3000;
  localparam int NI   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic [NI-1:0] miso_w, oe_w, prot_w;
  logic [8:0] chk_addr = '0;
  int vectors = 0;
  int errs = 0;
  bit done = 0;

  always #5 clk = ~clk;

  eep_spi_front #(.MEM_BYTES(512), .BUSY_CYCLES(BUSY)) i_eep_spi_front (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso_w[0]), .miso_oe(oe_w[0]), .chk_addr(chk_addr[8:0]), .chk_prot(prot_w[0]));
  eep_spi_front #(.MEM_BYTES(256), .BUSY_CYCLES(BUSY)) i_eep_spi_front_s256 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso_w[1]), .miso_oe(oe_w[1]), .chk_addr(chk_addr[7:0]), .chk_prot(prot_w[1]));
  eep_spi_front #(.MEM_BYTES(128), .BUSY_CYCLES(BUSY)) i_eep_spi_front_s128 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso_w[2]), .miso_oe(oe_w[2]), .chk_addr(chk_addr[6:0]), .chk_prot(prot_w[2]));

  function automatic int sz(input int k);
    return 512 >> k;
  endfunction

  function automatic int pat(input int a);
    return (a * 29 + 90) % 256;
  endfunction

  function automatic int exp_prot(input int a, input int bp, input int k);
    int m;
    m = a % sz(k);
    case (bp)
      0: return 0;
      1: return (m >= sz(k) * 3 / 4) ? 1 : 0;
      2: return (m >= sz(k) / 2) ? 1 : 0;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string req, input int k, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s size=%0d actual=%0h expected=%0h", req, sz(k), got, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bitx(input logic b, output logic [NI-1:0] q, output logic [NI-1:0] oe);
    sck = 1'b0; mosi = b;
    wclk(HALF);
    q = miso_w; oe = oe_w;
    sck = 1'b1;
    wclk(HALF);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    wclk(HALF);
  endtask

  task automatic desel();
    sck = 1'b0;
    wclk(HALF);
    cs_n = 1'b1;
    wclk(HALF);
  endtask

  task automatic send(input logic [7:0] v, inout logic [NI-1:0] seen);
    logic [NI-1:0] q, oe;
    for (int i = 7; i >= 0; i--) begin
      bitx(v[i], q, oe);
      seen |= oe;
    end
  endtask

  task automatic recv(output logic [NI-1:0][7:0] r, inout logic [NI-1:0] oe_all);
    logic [NI-1:0] q, oe;
    for (int i = 7; i >= 0; i--) begin
      bitx(1'b0, q, oe);
      for (int k = 0; k < NI; k++) r[k][i] = q[k];
      oe_all &= oe;
    end
  endtask

  task automatic do_read(input int a9, input int nb, input string req);
    logic [NI-1:0] seen, oe_all;
    logic [NI-1:0][7:0] r;
    logic [8:0] av;
    av = 9'(a9);
    seen = '0; oe_all = '1;
    sel();
    send({4'b0000, av[8], 3'b011}, seen);
    send(av[7:0], seen);
    for (int k = 0; k < NI; k++) chk({req, " R2 hi-Z in opcode/address"}, k, seen[k], 0);
    for (int n = 0; n < nb; n++) begin
      recv(r, oe_all);
      for (int k = 0; k < NI; k++)
        chk({req, " R3 R11 data"}, k, r[k], pat((a9 + n) % sz(k)));
    end
    for (int k = 0; k < NI; k++) chk({req, " R2 driven in data"}, k, oe_all[k], 1);
    desel();
  endtask

  task automatic rdsr(input int exp_bp, input int exp_busy, input string req);
    logic [NI-1:0] seen, oe_all;
    logic [NI-1:0][7:0] r;
    seen = '0; oe_all = '1;
    sel();
    send(8'h05, seen);
    recv(r, oe_all);
    for (int k = 0; k < NI; k++) chk({req, " R8 status"}, k, r[k], exp_bp * 4 + exp_busy);
    recv(r, oe_all);
    for (int k = 0; k < NI; k++) chk({req, " R8 status repeat"}, k, r[k], exp_bp * 4 + exp_busy);
    desel();
  endtask

  task automatic wrsr(input logic [7:0] v, input int nclk);
    logic [NI-1:0] seen, q, oe;
    seen = '0;
    sel();
    send(8'h01, seen);
    for (int i = 0; i < nclk - 8; i++) bitx((i < 8) ? v[7 - i] : 1'b0, q, oe);
    desel();
  endtask

  task automatic prot_sweep(input int bp);
    int al[12] = '{0, 95, 96, 127, 128, 191, 192, 255, 256, 383, 384, 511};
    for (int i = 0; i < 12; i++) begin
      chk_addr = 9'(al[i]);
      wclk(1);
      for (int k = 0; k < NI; k++) chk("R9 protect flag", k, prot_w[k], exp_prot(al[i], bp, k));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    logic [NI-1:0] seen, q, oe;
    void'($urandom(32'd20240611));
    wclk(4);
    rst = 1'b0;
    wclk(4);
    // R1: reset state
    for (int k = 0; k < NI; k++) chk("R1 oe after reset", k, oe_w[k], 0);
    rdsr(0, 0, "R1");
    prot_sweep(0);

    // R3 wrap at each size, R11 upper address bits
    do_read(9'h1FE, 4, "wrap512");
    do_read(9'h0FE, 4, "wrap256");
    do_read(9'h07E, 4, "wrap128");
    do_read(9'h110, 2, "a8set");
    for (int t = 0; t < 16; t++) do_read(int'($urandom % 512), 1 + int'($urandom % 4), "random");

    // R4: abort in the middle of a byte
    seen = '0;
    sel();
    send(8'h03, seen);
    send(8'h40, seen);
    bitx(1'b0, q, oe);
    bitx(1'b0, q, oe);
    bitx(1'b0, q, oe);
    for (int k = 0; k < NI; k++) chk("R4 driving before abort", k, oe[k], 1);
    desel();
    for (int k = 0; k < NI; k++) chk("R4 released after abort", k, oe_w[k], 0);
    do_read(9'h041, 1, "R4 after abort");

    // R10: unrecognised opcode
    seen = '0;
    sel();
    send(8'hA5, seen);
    send(8'h3C, seen);
    send(8'hFF, seen);
    for (int k = 0; k < NI; k++) chk("R10 ignored opcode keeps hi-Z", k, seen[k], 0);
    desel();
    rdsr(0, 0, "R10");

    // R6: 15 and 17 clocks abort
    wrsr(8'h0C, 15);
    wclk(20);
    rdsr(0, 0, "R6 15 clocks");
    wrsr(8'h0C, 17);
    wclk(20);
    rdsr(0, 0, "R6 17 clocks");

    // R6/R7: exact 16 clocks, BP=01
    wrsr(8'h04, 16);
    rdsr(1, 1, "R7 busy after commit");
    // R5: read during busy is rejected
    seen = '0;
    sel();
    send(8'h03, seen);
    send(8'h00, seen);
    send(8'h00, seen);
    send(8'h00, seen);
    for (int k = 0; k < NI; k++) chk("R5 read rejected while busy", k, seen[k], 0);
    desel();
    // R7: write-status during busy is ignored
    wrsr(8'h0C, 16);
    wclk(BUSY + 100);
    rdsr(1, 0, "R7 busy ended, second write ignored");
    prot_sweep(1);
    do_read(9'h1F0, 1, "R9 protected read allowed");

    wrsr(8'h08, 16);
    wclk(BUSY + 100);
    rdsr(2, 0, "R6 BP=10");
    prot_sweep(2);

    wrsr(8'hFF, 16);
    wclk(BUSY + 100);
    rdsr(3, 0, "R6 BP=11");
    prot_sweep(3);

    wrsr(8'hF3, 16);
    wclk(BUSY + 100);
    rdsr(0, 0, "R6 BP back to 00");
    prot_sweep(0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule